// File: doc/BRIEF.md
# Programmable Pattern Bit Error Tester

This block tests a serial link for bit errors. A transmit generator produces either a pseudo-random sequence from a programmable two-term feedback polynomial or a repeating word of 1 to 32 bits. Errors can be added on purpose, either one at a time or automatically at a decade rate. A receive monitor locks a 32-bit local generator onto the incoming stream and reports whether it is in sync. While in sync it counts received bits and bit errors.

The monitor first loads its shift register straight from the incoming data. It declares sync only after a run of correct predictions. From then on the register runs on its own predictions, so that one bad bit on the line counts as exactly one error. If too many errors arrive inside a fixed window, sync is dropped and the search starts again.

The live counters stop at their maximum value. A rising edge on the update input copies them to the output registers and clears them. A status flag and a sticky flag mark that the copy took place.

Top module: `prbs_bert`

## Requirements
- R1: In polynomial mode (`cfg_poly`=1) with length L=`cfg_len` (2..32) and tap T=`cfg_tap` (1..L-1), each transmitted bit b[n] equals b[n-L] XOR b[n-T]. The generator behaves as if the 32 bits before the first output after reset or restart were all ones.
- R2: In repetitive mode (`cfg_poly`=0), the transmitter sends the low L bits of `cfg_word` starting from bit L-1 and going down to bit 0, and repeats them without end.
- R3: Out of sync, the monitor shifts in the received bits and predicts each new bit with the rule of R1 or R2. It raises `in_sync` after VERIFY (48) consecutive correct predictions. Any wrong prediction restarts the run from zero.
- R4: In sync, the monitor drops `in_sync` when OOS_ERRS (6) errors occur inside one block of WIN (64) received bits. It then returns to searching.
- R5: A received bit is counted, and its error is counted, only when `in_sync` is high.
- R6: The bit counter and the error counter stop at all ones and never wrap.
- R7: A 0-to-1 transition of `pm_update` copies the live counters to `bit_count` and `err_count` at the next clock edge. The same edge clears the live counters.
- R8: `pm_status` goes high at the edge that copies the counters and stays high until `pm_update` is low. `pm_latched` is set at that same edge and stays set until `stat_clr` is asserted.
- R9: A non-zero `err_rate` code n (1..7) inverts one transmitted bit out of every 10^n. While the code is 0, the position count is held at zero, so the first inverted bit is the 10^n-th bit after the code is set. Code 0 inserts nothing.
- R10: A pulse on `err_one` inverts exactly one transmitted bit: the current bit if `tx_en` is high, otherwise the next bit sent.
- R11: A `restart` pulse reseeds the transmitter (all ones in polynomial mode, `cfg_word` in repetitive mode) and returns the monitor to searching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| restart | input | 1 | Reseed generator and restart search |
| cfg_poly | input | 1 | 1 = polynomial, 0 = repetitive word |
| cfg_len | input | 6 | Polynomial length or word length (1..32) |
| cfg_tap | input | 5 | Second feedback tap |
| cfg_word | input | 32 | Repetitive pattern word |
| err_rate | input | 3 | Automatic insertion rate code |
| err_one | input | 1 | Single error insert |
| tx_en | input | 1 | Transmit bit strobe |
| tx_bit | output | 1 | Transmitted bit |
| rx_en | input | 1 | Receive bit strobe |
| rx_bit | input | 1 | Received bit |
| in_sync | output | 1 | Monitor is locked |
| pm_update | input | 1 | Counter transfer request (rising edge) |
| stat_clr | input | 1 | Clears the sticky transfer flag |
| bit_count | output | BIT_W | Transferred bit count |
| err_count | output | ERR_W | Transferred error count |
| pm_status | output | 1 | Transfer status |
| pm_latched | output | 1 | Sticky transfer status |

## Verification
The bench builds the block with BIT_W=10 and ERR_W=4. With these widths, a run of 1400 bits carrying 20 spaced single errors drives both counters to their limits, which tests the stop-at-maximum behaviour in a short run. VERIFY, WIN and OOS_ERRS keep their defaults. Rate code 1 then gives six or seven errors in every 64-bit block, which forces loss of sync. Rate code 2 gives exactly ten errors in 1000 bits without disturbing sync.

// File: rtl/prbs_bert.sv
module prbs_bert #(
  parameter int BIT_W    = 32,
  parameter int ERR_W    = 24,
  parameter int INS_W    = 24,
  parameter int WIN      = 64,
  parameter int OOS_ERRS = 6,
  parameter int VERIFY   = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             cfg_poly,
  input  logic [5:0]       cfg_len,
  input  logic [4:0]       cfg_tap,
  input  logic [31:0]      cfg_word,
  input  logic [2:0]       err_rate,
  input  logic             err_one,
  input  logic             tx_en,
  output logic             tx_bit,
  input  logic             rx_en,
  input  logic             rx_bit,
  output logic             in_sync,
  input  logic             pm_update,
  input  logic             stat_clr,
  output logic [BIT_W-1:0] bit_count,
  output logic [ERR_W-1:0] err_count,
  output logic             pm_status,
  output logic             pm_latched
);
  localparam int WW = $clog2(WIN);
  localparam int EW = $clog2(OOS_ERRS + 1);
  localparam int MW = $clog2(VERIFY + 1);
  localparam logic [BIT_W-1:0] BMAX = '1;
  localparam logic [ERR_W-1:0] EMAX = '1;

  function automatic logic [INS_W-1:0] pow10m1(input logic [2:0] n);
    logic [31:0] v;
    v = 32'd1;
    for (int i = 0; i < 7; i++) if (i < int'(n)) v = v * 32'd10;
    return INS_W'(v - 32'd1);
  endfunction

  logic [4:0]  li, ti;
  logic [31:0] seed, tx_s, rx_s;
  logic        tx_fb, rx_fb, mism;
  assign li    = cfg_len[4:0] - 5'd1;
  assign ti    = cfg_tap - 5'd1;
  assign seed  = cfg_poly ? '1 : cfg_word;
  assign tx_fb = tx_s[li] ^ (cfg_poly & tx_s[ti]);
  assign rx_fb = rx_s[li] ^ (cfg_poly & rx_s[ti]);
  assign mism  = rx_fb ^ rx_bit;

  logic             pend, rate_hit, inject;
  logic [INS_W-1:0] ins_cnt;
  assign rate_hit = (err_rate != 3'd0) && (ins_cnt == pow10m1(err_rate));
  assign inject   = tx_en & (pend | err_one | rate_hit);
  assign tx_bit   = tx_fb ^ inject;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_s <= '1; pend <= 1'b0; ins_cnt <= '0;
    end else begin
      if (restart) tx_s <= seed;
      else if (tx_en) tx_s <= {tx_s[30:0], tx_fb};
      if (tx_en) pend <= 1'b0;
      else if (err_one) pend <= 1'b1;
      if (restart || err_rate == 3'd0) ins_cnt <= '0;
      else if (tx_en) ins_cnt <= rate_hit ? '0 : ins_cnt + 1'b1;
    end

  logic [MW-1:0] match;
  logic [WW-1:0] win;
  logic [EW-1:0] werr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_s <= '0; in_sync <= 1'b0; match <= '0; win <= '0; werr <= '0;
    end else if (restart) begin
      rx_s <= '0; in_sync <= 1'b0; match <= '0; win <= '0; werr <= '0;
    end else if (rx_en) begin
      if (!in_sync) begin
        rx_s <= {rx_s[30:0], rx_bit};
        if (mism) match <= '0;
        else if (match == MW'(VERIFY - 1)) begin
          in_sync <= 1'b1; match <= '0; win <= '0; werr <= '0;
        end else match <= match + 1'b1;
      end else begin
        rx_s <= {rx_s[30:0], rx_fb};
        win  <= (win == WW'(WIN - 1)) ? '0 : win + 1'b1;
        if (mism && werr == EW'(OOS_ERRS - 1)) begin
          in_sync <= 1'b0; werr <= '0;
        end else if (win == WW'(WIN - 1)) werr <= '0;
        else werr <= werr + EW'(mism);
      end
    end

  logic             upd_q, upd_rise, cnt_bit, cnt_err;
  logic [BIT_W-1:0] bit_cnt;
  logic [ERR_W-1:0] err_cnt;
  assign upd_rise = pm_update & ~upd_q;
  assign cnt_bit  = rx_en & in_sync;
  assign cnt_err  = cnt_bit & mism;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      upd_q <= 1'b0; bit_cnt <= '0; err_cnt <= '0; bit_count <= '0;
      err_count <= '0; pm_status <= 1'b0; pm_latched <= 1'b0;
    end else begin
      upd_q <= pm_update;
      if (upd_rise) begin
        bit_count <= bit_cnt;
        err_count <= err_cnt;
        bit_cnt   <= BIT_W'(cnt_bit);
        err_cnt   <= ERR_W'(cnt_err);
      end else begin
        if (cnt_bit && bit_cnt != BMAX) bit_cnt <= bit_cnt + 1'b1;
        if (cnt_err && err_cnt != EMAX) err_cnt <= err_cnt + 1'b1;
      end
      if (upd_rise) pm_status <= 1'b1;
      else if (!pm_update) pm_status <= 1'b0;
      if (upd_rise) pm_latched <= 1'b1;
      else if (stat_clr) pm_latched <= 1'b0;
    end

  p_search_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sync && rx_en && mism |=> !in_sync);
  p_hold_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync && !restart && !(rx_en && mism) |=> in_sync);
  p_err_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt == EMAX && !upd_rise |=> err_cnt == EMAX);
  p_bit_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt == BMAX && !upd_rise |=> bit_cnt == BMAX);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_rise |=> bit_cnt <= BIT_W'(1) && err_cnt <= ERR_W'(1));
  p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pm_status) |-> $past(pm_update));
  p_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pm_status && !stat_clr |=> pm_latched);
endmodule

// File: tb/prbs_bert_bench.sv
module prbs_bert_bench;
  localparam int CLK_P = 10;
  localparam int BW = 10, EWD = 4;

  logic clk = 0, rst_n = 0, restart = 0, cfg_poly = 1, err_one = 0;
  logic tx_en = 0, pm_update = 0, stat_clr = 0;
  logic [5:0] cfg_len = 6'd15;
  logic [4:0] cfg_tap = 5'd14;
  logic [31:0] cfg_word = 32'h0;
  logic [2:0] err_rate = 3'd0;
  logic tx_bit, in_sync, pm_status, pm_latched;
  logic [BW-1:0] bit_count;
  logic [EWD-1:0] err_count;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  prbs_bert #(.BIT_W(BW), .ERR_W(EWD)) u_prbs_bert (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cfg_poly(cfg_poly),
    .cfg_len(cfg_len), .cfg_tap(cfg_tap), .cfg_word(cfg_word),
    .err_rate(err_rate), .err_one(err_one), .tx_en(tx_en), .tx_bit(tx_bit),
    .rx_en(tx_en), .rx_bit(tx_bit), .in_sync(in_sync), .pm_update(pm_update),
    .stat_clr(stat_clr), .bit_count(bit_count), .err_count(err_count),
    .pm_status(pm_status), .pm_latched(pm_latched));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); tx_en = 1; end
    @(negedge clk); tx_en = 0;
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1; @(negedge clk); restart = 0;
  endtask

  task automatic update(output int b, output int e);
    @(negedge clk); tx_en = 0; pm_update = 1;
    @(negedge clk);
    b = bit_count; e = err_count;
    chk("R8 status", pm_status, 1);
    pm_update = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R5 sync at reset", in_sync, 0);
    chk("R7 bits at reset", bit_count, 0);
    chk("R7 errs at reset", err_count, 0);
    chk("R8 latched at reset", pm_latched, 0);
  endtask

  task automatic t_poly_tx();
    logic [31:0] m = '1;
    int bad = 0;
    cfg_poly = 1; cfg_len = 15; cfg_tap = 14;
    do_restart();
    for (int i = 0; i < 60; i++) begin
      logic nb;
      nb = m[14] ^ m[13];
      @(negedge clk); tx_en = 1; #1;
      if (tx_bit !== nb) bad++;
      m = {m[30:0], nb};
    end
    @(negedge clk); tx_en = 0;
    chk("R1/R11 polynomial sequence mismatches", bad, 0);
  endtask

  task automatic t_sync();
    run(100);
    chk("R3 sync acquired", in_sync, 1);
  endtask

  task automatic t_count();
    int b, e;
    update(b, e);
    run(500);
    update(b, e);
    chk("R5/R7 bit count", b, 500);
    chk("R5/R7 err count", e, 0);
    chk("R8 status follows update low", pm_status, 0);
    chk("R8 latched", pm_latched, 1);
  endtask

  task automatic t_manual();
    int b, e;
    @(negedge clk); tx_en = 1; err_one = 1;
    @(negedge clk); err_one = 0; tx_en = 0;
    run(299);
    update(b, e);
    chk("R10 single error bits", b, 300);
    chk("R10 single error count", e, 1);
    chk("R10 sync kept", in_sync, 1);
  endtask

  task automatic t_rate();
    int b, e;
    @(negedge clk); err_rate = 3'd2;
    run(1000);
    @(negedge clk); err_rate = 3'd0;
    update(b, e);
    chk("R9 rate bits", b, 1000);
    chk("R9 rate errors 1e-2", e, 10);
  endtask

  task automatic t_oos();
    @(negedge clk); err_rate = 3'd1;
    run(130);
    chk("R4 sync lost", in_sync, 0);
    @(negedge clk); err_rate = 3'd0;
    run(100);
    chk("R3 resync", in_sync, 1);
  endtask

  task automatic t_sat();
    int b, e;
    update(b, e);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); tx_en = 1; err_one = 1;
      @(negedge clk); err_one = 0; tx_en = 0;
      run(69);
    end
    update(b, e);
    chk("R6 err saturate", e, 15);
    chk("R6 bit saturate", b, 1023);
  endtask

  task automatic t_rep();
    int bad = 0, b, e;
    cfg_poly = 0; cfg_len = 8; cfg_word = 32'h0000_00A7;
    do_restart();
    chk("R11 restart drops sync", in_sync, 0);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); tx_en = 1; #1;
      if (tx_bit !== cfg_word[7 - (i % 8)]) bad++;
    end
    @(negedge clk); tx_en = 0;
    chk("R2 repetitive mismatches", bad, 0);
    run(100);
    chk("R3 repetitive sync", in_sync, 1);
    update(b, e);
    run(200);
    update(b, e);
    chk("R2 repetitive bits", b, 200);
    chk("R2 repetitive errs", e, 0);
  endtask

  task automatic t_latch();
    @(negedge clk); stat_clr = 1; @(negedge clk); stat_clr = 0;
    chk("R8 latched cleared", pm_latched, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset(); t_poly_tx(); t_sync(); t_count(); t_manual();
        t_rate(); t_oos(); t_sat(); t_rep(); t_latch();
        done = 1;
      end
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule